// File: doc/BRIEF.md
# Auto-indexed SMBus block buffer

This block is a 32-byte staging memory that sits between a byte-wide register bus and an SMBus transaction sequencer. Software moves a whole block through one block-data register. An internal host pointer steps forward on every access, and reading the host control register returns that pointer to zero. Before a block write, software loads the byte count into the data0 register. After a block read, the sequencer leaves the count it received from the slave in data0. The block checks that count and flags it when it is out of range.

The sequencer has its own pointer. It is cleared when a transfer starts. The sequencer then fetches bytes in order for an outgoing transfer, or stores received bytes in order for an incoming one. Two bits in the auxiliary control register control the mode: one turns on the 32-byte buffer mode, the other turns on hardware PEC. When buffer mode is off, the block-data register becomes a single holding byte that both sides share, and the memory and pointers stay as they are.

Top module: `smbus_blkbuf`

## Requirements
- R1: The buffer holds 32 bytes. Thirty-two consecutive block-data writes followed by 32 reads return all 32 bytes unchanged.
- R2: The control register (select 0) reads back the last byte written to it. Each read of it sets the host pointer to entry 0.
- R3: In buffer mode, each block-data (select 2) write stores at the host pointer, and each block-data read returns the byte at the host pointer. Each such access then advances the pointer by one.
- R4: The host pointer wraps from entry 31 to entry 0. A 33rd write replaces entry 0 only.
- R5: In the auxiliary register (select 3), bit 1 is the buffer-mode enable and bit 0 is the PEC enable. Both read back as written, bits 7:2 read 0, and the outputs buf_mode and pec_en follow the two bits.
- R6: data0 (select 1) drives xfer_len and reads back. A host write sets it, and a sequencer count load replaces it with the received count.
- R7: cnt_bad rises after a sequencer count load of 0 or of more than 32. A load of 1 to 32, or a host write to data0, clears it.
- R8: seq_start sets the sequencer pointer to entry 0. Each seq_rd presents the entries in order from 0, and each seq_wr stores into consecutive entries, which the host can then read back.
- R9: With buffer mode off, block-data accesses and sequencer accesses use a single holding byte. The host pointer and the 32 entries are left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_sel | input | 2 | Register select: 0 control, 1 data0, 2 block data, 3 auxiliary |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the current select |
| seq_start | input | 1 | Transfer start; clears the sequencer pointer |
| seq_rd | input | 1 | Sequencer fetch strobe; advances its pointer |
| seq_wr | input | 1 | Sequencer store strobe |
| seq_wdata | input | 8 | Byte stored by the sequencer |
| seq_rdata | output | 8 | Byte at the sequencer pointer |
| seq_cnt_ld | input | 1 | Load the received count into data0 |
| seq_cnt | input | 8 | Count received from the slave |
| xfer_len | output | 8 | Current data0 value (transfer length) |
| buf_mode | output | 1 | Buffer mode enabled |
| pec_en | output | 1 | Hardware PEC enabled |
| cnt_bad | output | 1 | Last received count was out of range |

## Verification
The bench goes after the pointer edges. A 33rd write that spilled past entry 31 into some other entry would corrupt a neighbour, which the full read-back after the wrap exposes. A design that failed to rewind on a control read would return later entries. The count limits are probed at 0, 1, 32, 33 and 255. An off-by-one comparison would flag 32 as bad or let 33 through. The bench also turns buffer mode off partway through a block and then back on. A design that kept advancing the pointer, or that wrote the holding byte into the memory, would return the wrong entry after re-enabling.

// File: rtl/smbuf_pkg.sv
package smbuf_pkg;
    localparam int BUF_DEPTH  = 32;
    localparam int BYTE_W     = 8;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_DATA0 = 2'd1,
        SEL_BLK   = 2'd2,
        SEL_AUX   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/smbuf_regs.sv
module smbuf_regs
    import smbuf_pkg::*;
#(
    parameter int W       = BYTE_W,
    parameter int MAX_CNT = BUF_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ctrl,
    input  logic         wr_data0,
    input  logic         wr_aux,
    input  logic [W-1:0] wdata,
    input  logic         cnt_load,
    input  logic [W-1:0] cnt_in,
    output logic [W-1:0] ctrl_val,
    output logic [W-1:0] data0_val,
    output logic         buf_en,
    output logic         pec_on,
    output logic         cnt_bad
);
    localparam logic [W-1:0] MAX_B = W'(MAX_CNT);

    typedef struct packed {
        logic [W-1:0] ctrl;
        logic [W-1:0] data0;
        logic         buf_en;
        logic         pec_on;
        logic         bad;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) st_d.ctrl = wdata;
        if (wr_aux) begin
            st_d.buf_en = wdata[1];
            st_d.pec_on = wdata[0];
        end
        if (cnt_load) begin
            st_d.data0 = cnt_in;
            st_d.bad   = (cnt_in == '0) || (cnt_in > MAX_B);
        end else if (wr_data0) begin
            st_d.data0 = wdata;
            st_d.bad   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_val  = st_q.ctrl;
    assign data0_val = st_q.data0;
    assign buf_en    = st_q.buf_en;
    assign pec_on    = st_q.pec_on;
    assign cnt_bad   = st_q.bad;

    AST_CNT_ZERO_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_load && cnt_in == '0) |=> cnt_bad); // R7
    AST_CNT_LOAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> (data0_val == $past(cnt_in))); // R6
endmodule

// File: rtl/smbuf_store.sv
module smbuf_store
    import smbuf_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    parameter int W     = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         buf_en,
    input  logic         idx_clr,
    input  logic         host_wr,
    input  logic         host_rd,
    input  logic [W-1:0] host_wdata,
    output logic [W-1:0] host_rdata,
    input  logic         seq_start,
    input  logic         seq_rd,
    input  logic         seq_wr,
    input  logic [W-1:0] seq_wdata,
    output logic [W-1:0] seq_rdata
);
    localparam int IW = $clog2(DEPTH);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [W-1:0]            hold;
        logic [IW-1:0]           hidx;
        logic [IW-1:0]           sidx;
    } store_t;

    store_t st_d, st_q;

    function automatic logic [IW-1:0] step(input logic [IW-1:0] i);
        return (i == LAST) ? '0 : i + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (buf_en) begin
            if (host_wr) st_d.mem[st_q.hidx] = host_wdata;
            if (host_wr || host_rd) st_d.hidx = step(st_q.hidx);
            if (seq_wr) st_d.mem[st_q.sidx] = seq_wdata;
            if (seq_wr || seq_rd) st_d.sidx = step(st_q.sidx);
        end else begin
            if (host_wr) st_d.hold = host_wdata;
            if (seq_wr)  st_d.hold = seq_wdata;
        end
        if (idx_clr)   st_d.hidx = '0;
        if (seq_start) st_d.sidx = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rdata = buf_en ? st_q.mem[st_q.hidx] : st_q.hold;
    assign seq_rdata  = buf_en ? st_q.mem[st_q.sidx] : st_q.hold;

    AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        idx_clr |=> (st_q.hidx == '0)); // R2
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en && (host_wr || host_rd) && !idx_clr)
        |=> (st_q.hidx == (($past(st_q.hidx) == LAST) ? '0 : $past(st_q.hidx) + 1'b1))); // R3
    AST_SEQ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> (st_q.sidx == '0)); // R8
    AST_HOLD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_en && !idx_clr) |=> $stable(st_q.hidx)); // R9
    AST_HOLD_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_en |=> $stable(st_q.mem)); // R9
endmodule

// File: rtl/smbus_blkbuf.sv
module smbus_blkbuf
    import smbuf_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    parameter int W     = BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic         reg_rd,
    input  logic [1:0]   reg_sel,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         seq_start,
    input  logic         seq_rd,
    input  logic         seq_wr,
    input  logic [W-1:0] seq_wdata,
    output logic [W-1:0] seq_rdata,
    input  logic         seq_cnt_ld,
    input  logic [W-1:0] seq_cnt,
    output logic [W-1:0] xfer_len,
    output logic         buf_mode,
    output logic         pec_en,
    output logic         cnt_bad
);
    logic         sel_ctrl, sel_data0, sel_blk, sel_aux;
    logic [W-1:0] ctrl_val, blk_rdata;

    always_comb begin
        sel_ctrl  = (reg_sel == SEL_CTRL);
        sel_data0 = (reg_sel == SEL_DATA0);
        sel_blk   = (reg_sel == SEL_BLK);
        sel_aux   = (reg_sel == SEL_AUX);
    end

    smbuf_regs #(.W(W), .MAX_CNT(DEPTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (reg_wr && sel_ctrl),
        .wr_data0  (reg_wr && sel_data0),
        .wr_aux    (reg_wr && sel_aux),
        .wdata     (reg_wdata),
        .cnt_load  (seq_cnt_ld),
        .cnt_in    (seq_cnt),
        .ctrl_val  (ctrl_val),
        .data0_val (xfer_len),
        .buf_en    (buf_mode),
        .pec_on    (pec_en),
        .cnt_bad   (cnt_bad)
    );

    smbuf_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_en     (buf_mode),
        .idx_clr    (reg_rd && sel_ctrl),
        .host_wr    (reg_wr && sel_blk),
        .host_rd    (reg_rd && sel_blk),
        .host_wdata (reg_wdata),
        .host_rdata (blk_rdata),
        .seq_start  (seq_start),
        .seq_rd     (seq_rd),
        .seq_wr     (seq_wr),
        .seq_wdata  (seq_wdata),
        .seq_rdata  (seq_rdata)
    );

    always_comb begin
        unique case (reg_sel)
            SEL_CTRL:  reg_rdata = ctrl_val;
            SEL_DATA0: reg_rdata = xfer_len;
            SEL_BLK:   reg_rdata = blk_rdata;
            default:   reg_rdata = {{(W-2){1'b0}}, buf_mode, pec_en};
        endcase
    end

    AST_AUX_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel_aux) |=> ({buf_mode, pec_en} == $past(reg_wdata[1:0]))); // R5
    AST_DATA0_CLEARS_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel_data0 && !seq_cnt_ld) |=> !cnt_bad); // R7
endmodule

// File: tb/smbus_blkbuf_test.sv
`timescale 1ns/1ps
module smbus_blkbuf_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       seq_start = 1'b0, seq_rd = 1'b0, seq_wr = 1'b0;
    logic [7:0] seq_wdata = 8'h00;
    logic [7:0] seq_rdata;
    logic       seq_cnt_ld = 1'b0;
    logic [7:0] seq_cnt = 8'h00;
    logic [7:0] xfer_len;
    logic       buf_mode, pec_en, cnt_bad;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [7:0] model [32];

    always #2.5 clk = ~clk;

    smbus_blkbuf uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .seq_start(seq_start), .seq_rd(seq_rd), .seq_wr(seq_wr),
        .seq_wdata(seq_wdata), .seq_rdata(seq_rdata),
        .seq_cnt_ld(seq_cnt_ld), .seq_cnt(seq_cnt), .xfer_len(xfer_len),
        .buf_mode(buf_mode), .pec_en(pec_en), .cnt_bad(cnt_bad)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic load_count(input logic [7:0] c);
        @(negedge clk);
        seq_cnt = c; seq_cnt_ld = 1'b1;
        @(negedge clk);
        seq_cnt_ld = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        reg_read(2'd3, v);
        chk("R5 aux after reset", v, 8'h00);
        chk("R6 xfer_len after reset", xfer_len, 8'h00);
        chk("R7 cnt_bad after reset", {7'd0, cnt_bad}, 8'h00);
    endtask

    task automatic t_aux;
        logic [7:0] v;
        reg_write(2'd3, 8'hFF);
        reg_read(2'd3, v);
        chk("R5 aux FF readback", v, 8'h03);
        chk("R5 outputs", {6'd0, buf_mode, pec_en}, 8'h03);
        reg_write(2'd3, 8'h01);
        reg_read(2'd3, v);
        chk("R5 aux pec only", v, 8'h01);
        reg_write(2'd3, 8'h02);
        reg_read(2'd3, v);
        chk("R5 aux buffer only", v, 8'h02);
    endtask

    task automatic t_fill;
        logic [7:0] v;
        reg_read(2'd0, v);
        for (int i = 0; i < 32; i++) begin
            model[i] = 8'(i * 7 + 3);
            reg_write(2'd2, model[i]);
        end
        reg_read(2'd0, v);
        for (int i = 0; i < 32; i++) begin
            reg_read(2'd2, v);
            chk($sformatf("R1 R3 entry %0d", i), v, model[i]);
        end
    endtask

    task automatic t_ctrl;
        logic [7:0] v;
        reg_write(2'd0, 8'h5A);
        reg_read(2'd0, v);
        chk("R2 control readback", v, 8'h5A);
        for (int i = 0; i < 3; i++) begin
            reg_read(2'd2, v);
            chk("R2 R3 after rewind", v, model[i]);
        end
        reg_read(2'd0, v);
        reg_read(2'd2, v);
        chk("R2 second rewind", v, model[0]);
    endtask

    task automatic t_wrap;
        logic [7:0] v;
        reg_read(2'd0, v);
        for (int i = 0; i < 32; i++) begin
            model[i] = 8'(8'h80 + i);
            reg_write(2'd2, model[i]);
        end
        reg_write(2'd2, 8'hEE);
        model[0] = 8'hEE;
        reg_read(2'd0, v);
        for (int i = 0; i < 32; i++) begin
            reg_read(2'd2, v);
            chk($sformatf("R4 entry %0d after wrap", i), v, model[i]);
        end
    endtask

    task automatic t_seq;
        logic [7:0] v;
        @(negedge clk); seq_start = 1'b1;
        @(negedge clk); seq_start = 1'b0;
        for (int i = 0; i < 32; i++) begin
            chk($sformatf("R8 fetch %0d", i), seq_rdata, model[i]);
            seq_rd = 1'b1;
            @(negedge clk); seq_rd = 1'b0;
        end
        @(negedge clk); seq_start = 1'b1;
        @(negedge clk); seq_start = 1'b0;
        for (int i = 0; i < 5; i++) begin
            seq_wdata = 8'(8'h40 + i); seq_wr = 1'b1;
            model[i] = seq_wdata;
            @(negedge clk); seq_wr = 1'b0;
        end
        reg_read(2'd0, v);
        for (int i = 0; i < 6; i++) begin
            reg_read(2'd2, v);
            chk($sformatf("R8 stored %0d", i), v, model[i]);
        end
    endtask

    task automatic t_data0;
        logic [7:0] v;
        reg_write(2'd1, 8'h10);
        reg_read(2'd1, v);
        chk("R6 data0 readback", v, 8'h10);
        chk("R6 xfer_len host", xfer_len, 8'h10);
        load_count(8'd32);
        chk("R6 xfer_len loaded", xfer_len, 8'd32);
        chk("R7 count 32 valid", {7'd0, cnt_bad}, 8'h00);
        load_count(8'd0);
        chk("R7 count 0 bad", {7'd0, cnt_bad}, 8'h01);
        load_count(8'd1);
        chk("R7 count 1 valid", {7'd0, cnt_bad}, 8'h00);
        load_count(8'd33);
        chk("R7 count 33 bad", {7'd0, cnt_bad}, 8'h01);
        reg_write(2'd1, 8'h05);
        chk("R7 host write clears", {7'd0, cnt_bad}, 8'h00);
        load_count(8'hFF);
        chk("R7 count FF bad", {7'd0, cnt_bad}, 8'h01);
        chk("R6 xfer_len FF", xfer_len, 8'hFF);
    endtask

    task automatic t_hold;
        logic [7:0] v;
        reg_read(2'd0, v);
        reg_read(2'd2, v);
        reg_read(2'd2, v);
        reg_write(2'd3, 8'h00);
        reg_write(2'd2, 8'hC3);
        reg_read(2'd2, v);
        chk("R9 holding byte", v, 8'hC3);
        reg_read(2'd2, v);
        chk("R9 holding no advance", v, 8'hC3);
        @(negedge clk); seq_wdata = 8'h3C; seq_wr = 1'b1;
        @(negedge clk); seq_wr = 1'b0;
        chk("R9 sequencer sees hold", seq_rdata, 8'h3C);
        reg_read(2'd2, v);
        chk("R9 host sees sequencer byte", v, 8'h3C);
        reg_write(2'd3, 8'h02);
        reg_read(2'd2, v);
        chk("R9 index and entry kept", v, model[2]);
        reg_read(2'd2, v);
        chk("R9 next entry kept", v, model[3]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_aux();
        t_fill();
        t_ctrl();
        t_wrap();
        t_seq();
        t_data0();
        t_hold();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements) act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule